// File: doc/BRIEF.md
# ATM Cell-Layer Interrupt Status Register

This block collects error and condition events from the receive and transmit halves of a 25.6 Mb/s ATM physical-layer transmission-convergence stage. It folds them into one 8-bit status word that a host processor reads through a small register port. Most fields are sticky event flags. They are set by local detectors: a short-cell detector that counts receive bytes between start-of-cell markers, an edge detector on the signal-quality level, and an odd-parity checker on transmit bytes that can be switched off. The remaining events come in as plain strobes: HEC error, undefined 5-bit symbol and receive FIFO overflow.

One further field shows the live signal-quality state. The interrupt output is raised while any sticky flag is set. A read of the register returns the flags and clears them in the same access, so software sees each event once.

Top module: `irq_stat_top`

## Requirements
- R1: A read hits the register only when `rdEn` is 1 and `rdAddr` equals 0x01. A read with `rdEn` at 1 at any other address returns 0x00 and leaves every flag unchanged.
- R2: After reset, every sticky flag and the signal-quality bit are 0. A read returns 0x00 and `irqOut` is 0.
- R3: Bit layout of the read word: bit 7 is reserved and always reads 0, bit 6 is signal good, bit 5 is HEC error, bit 4 is short cell, bit 3 is transmit parity error, bit 2 is signal change, bit 1 is symbol error and bit 0 is receive FIFO overflow.
- R4: A one-cycle pulse on `hecErrStb`, `symErrStb` or `fifoOvfStb` sets its flag from the next cycle on, and the flag stays set until a read.
- R5: A read returns the flags as they stood before that cycle and then clears them. An event that arrives in the same cycle as the read is still set afterwards.
- R6: Bit 6 shows `sigGood` as sampled at the previous clock edge. It is read-only, and a read does not clear it.
- R7: The signal-change flag sets when `sigGood` changes in either direction, bad to good or good to bad.
- R8: While `parityChkEn` is 1, a transmit byte (`txDataValid` = 1) whose 8 data bits and `txParity` together hold an even number of ones sets the parity error flag. Parity is odd. While `parityChkEn` is 0, no transmit byte sets the flag.
- R9: A receive start-of-cell marker sets the short-cell flag when fewer than CELL_BYTES (53) `rxByteValid` bytes have arrived since the previous marker. The first marker after reset never sets it.
- R10: The byte counter restarts at each marker and saturates at CELL_BYTES. A gap of CELL_BYTES or more bytes, however long, does not set the short-cell flag.
- R11: `irqOut` is the OR of the six sticky flags (bits 5 to 0). The signal-quality bit does not drive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxCellStart | input | 1 | Receive start-of-cell marker |
| rxByteValid | input | 1 | One receive cell byte this cycle |
| hecErrStb | input | 1 | Received cell had a HEC error |
| symErrStb | input | 1 | Undefined 5-bit symbol received |
| fifoOvfStb | input | 1 | Receive FIFO full, data refused |
| sigGood | input | 1 | Signal-quality level, 1 = good |
| txDataValid | input | 1 | Transmit byte present |
| txData | input | DATA_W | Transmit byte |
| txParity | input | 1 | Odd parity bit for the transmit byte |
| parityChkEn | input | 1 | Enable for the transmit parity check |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | 8 | Read data, 0x00 when not hit |
| irqOut | output | 1 | Interrupt, high while any flag is set |

## Verification
The bench builds the block with its default parameters: CELL_BYTES = 53, DATA_W = 8 and an 8-bit address with the register at 0x01. With these values, gaps of 52, 53 and 70 bytes test one below the short-cell limit, exactly at it, and beyond the counter's saturation point. The 8-bit data width lets hand-picked bytes exercise both odd and even parity, with the check enabled and disabled. Reads that coincide with fresh events, and reads at a neighbouring address, test the clear priority and the address decode.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  // Field order matches read-word bits 5..0
  typedef struct packed {
    logic hecErr;
    logic shortCell;
    logic parityErr;
    logic sigChange;
    logic symErr;
    logic fifoOvf;
  } evtStrobe_t;

  localparam int EVT_W    = $bits(evtStrobe_t);
  localparam int BIT_GOOD = 6;
  localparam int BIT_RSVD = 7;

endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxCellStart,
  input  logic              rxByteValid,
  input  logic              hecErrStb,
  input  logic              symErrStb,
  input  logic              fifoOvfStb,
  input  logic              sigGood,
  input  logic              txDataValid,
  input  logic [DATA_W-1:0] txData,
  input  logic              txParity,
  input  logic              parityChkEn,
  output evtStrobe_t        strobes,
  output logic              goodNow
);

  localparam int CNT_W = $clog2(CELL_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CELL_BYTES);

  logic [CNT_W-1:0] gapCnt;
  logic             seenStart;
  logic             sigPrev;
  logic             parityOnes;

  // Byte gap counter: restarts on a marker, saturates at CELL_BYTES
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt    <= '0;
      seenStart <= 1'b0;
      sigPrev   <= 1'b0;
    end else begin
      sigPrev <= sigGood;
      if (rxCellStart) begin
        gapCnt    <= '0;
        seenStart <= 1'b1;
      end else if (rxByteValid && (gapCnt != CNT_MAX)) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  assign parityOnes = ^{txParity, txData};

  always_comb begin
    strobes.hecErr    = hecErrStb;
    strobes.symErr    = symErrStb;
    strobes.fifoOvf   = fifoOvfStb;
    strobes.shortCell = rxCellStart && seenStart && (gapCnt < CNT_MAX);
    strobes.parityErr = txDataValid && parityChkEn && !parityOnes;
    strobes.sigChange = sigGood ^ sigPrev;
  end

  assign goodNow = sigPrev;

endmodule

// File: rtl/irq_stat_dp.sv
module irq_stat_dp
  import irq_stat_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtStrobe_t        strobes,
  input  logic              goodNow,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              irqOut,
  output logic [EVT_W-1:0]  stickyBits
);

  logic [EVT_W-1:0] strobeVec;
  logic             readHit;

  assign strobeVec = strobes;
  assign readHit   = rdEn && (rdAddr == REG_ADDR);

  // New events win over the clear of a same-cycle read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyBits <= '0;
    end else begin
      stickyBits <= (readHit ? '0 : stickyBits) | strobeVec;
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (readHit) begin
      rdData[EVT_W-1:0] = stickyBits;
      rdData[BIT_GOOD]  = goodNow;
      rdData[BIT_RSVD]  = 1'b0;
    end
  end

  assign irqOut = |stickyBits;

endmodule

// File: rtl/irq_stat_top.sv
module irq_stat_top
  import irq_stat_pkg::*;
#(
  parameter int                CELL_BYTES = 53,
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxCellStart,
  input  logic              rxByteValid,
  input  logic              hecErrStb,
  input  logic              symErrStb,
  input  logic              fifoOvfStb,
  input  logic              sigGood,
  input  logic              txDataValid,
  input  logic [DATA_W-1:0] txData,
  input  logic              txParity,
  input  logic              parityChkEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              irqOut
);

  evtStrobe_t       strobes;
  logic             goodNow;
  logic [EVT_W-1:0] stickyBits;

  irq_stat_ctrl #(
    .CELL_BYTES(CELL_BYTES),
    .DATA_W    (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxCellStart(rxCellStart),
    .rxByteValid(rxByteValid),
    .hecErrStb  (hecErrStb),
    .symErrStb  (symErrStb),
    .fifoOvfStb (fifoOvfStb),
    .sigGood    (sigGood),
    .txDataValid(txDataValid),
    .txData     (txData),
    .txParity   (txParity),
    .parityChkEn(parityChkEn),
    .strobes    (strobes),
    .goodNow    (goodNow)
  );

  irq_stat_dp #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .goodNow   (goodNow),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .stickyBits(stickyBits)
  );

endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h01
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic              irqOut,
  input logic              hecErrStb,
  input logic              sigGood,
  input logic              parityChkEn,
  input logic [5:0]        stickyBits
);

  logic readHit;
  assign readHit = rdEn && (rdAddr == REG_ADDR);

  // R4
  hec_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hecErrStb |=> stickyBits[5]);

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readHit |=> ((stickyBits & $past(stickyBits)) == $past(stickyBits)));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readHit && !hecErrStb) |=> !stickyBits[5]);

  // R7
  sig_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sigGood) |=> stickyBits[2]);

  // R8
  parity_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!parityChkEn && !stickyBits[3]) |=> !stickyBits[3]);

  // R11
  irq_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    readHit |-> (irqOut == (|rdData[5:0])));

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[7]);

endmodule

bind irq_stat_top irq_stat_chk #(
  .ADDR_W  (ADDR_W),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdEn       (rdEn),
  .rdAddr     (rdAddr),
  .rdData     (rdData),
  .irqOut     (irqOut),
  .hecErrStb  (hecErrStb),
  .sigGood    (sigGood),
  .parityChkEn(parityChkEn),
  .stickyBits (stickyBits)
);

// File: tb/irq_stat_top_bench.sv
`timescale 1ns/1ps
module irq_stat_top_bench;

  localparam int CELL = 53;

  typedef struct {
    logic [7:0] data;
    logic       irq;
    string      req;
  } item_t;

  item_t sbq[$];

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxCellStart = 1'b0, rxByteValid = 1'b0;
  logic       hecErrStb = 1'b0, symErrStb = 1'b0, fifoOvfStb = 1'b0;
  logic       sigGood = 1'b0;
  logic       txDataValid = 1'b0, txParity = 1'b0, parityChkEn = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       rdEn = 1'b0;
  logic [7:0] rdAddr = 8'h00;
  logic [7:0] rdData;
  logic       irqOut;

  logic [5:0] mSticky = '0;
  logic       mSigPrev = 1'b0;
  int         mCnt = 0;
  bit         mSeen = 1'b0;
  int         nCmp = 0, nBad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  irq_stat_top #(.CELL_BYTES(CELL)) u_irq_stat_top (
    .clk(clk), .rstN(rstN), .rxCellStart(rxCellStart), .rxByteValid(rxByteValid),
    .hecErrStb(hecErrStb), .symErrStb(symErrStb), .fifoOvfStb(fifoOvfStb),
    .sigGood(sigGood), .txDataValid(txDataValid), .txData(txData),
    .txParity(txParity), .parityChkEn(parityChkEn), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  // Driver: computes expectations from the requirements, one cycle per call
  task automatic tick(input string req);
    logic [5:0] s;
    bit hit;
    item_t it;
    hit = rdEn && (rdAddr == 8'h01);
    s = '0;
    s[5] = hecErrStb;
    s[1] = symErrStb;
    s[0] = fifoOvfStb;
    s[3] = txDataValid && parityChkEn && !(^{txParity, txData});
    s[2] = (sigGood != mSigPrev);
    s[4] = rxCellStart && mSeen && (mCnt < CELL);
    if (rdEn) begin
      it.data = hit ? {1'b0, mSigPrev, mSticky} : 8'h00;
      it.irq  = |mSticky;
      it.req  = req;
      sbq.push_back(it);
    end
    @(posedge clk);
    mSticky  = (hit ? 6'h00 : mSticky) | s;
    mSigPrev = sigGood;
    if (rxCellStart) begin
      mCnt = 0;
      mSeen = 1'b1;
    end else if (rxByteValid && mCnt < CELL) begin
      mCnt = mCnt + 1;
    end
    @(negedge clk);
    rxCellStart = 1'b0; rxByteValid = 1'b0;
    hecErrStb = 1'b0; symErrStb = 1'b0; fifoOvfStb = 1'b0;
    txDataValid = 1'b0; rdEn = 1'b0; rdAddr = 8'h00;
  endtask

  task automatic readReg(input string req);
    rdEn = 1'b1; rdAddr = 8'h01;
    tick(req);
  endtask

  task automatic sendBytes(input int n);
    for (int i = 0; i < n; i++) begin
      rxByteValid = 1'b1;
      tick("R10");
    end
  endtask

  task automatic marker(input string req);
    rxCellStart = 1'b1;
    tick(req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  // Monitor: pops one expected item per read, 1 ns after the driving edge
  always @(negedge clk) begin
    #1;
    if (rdEn && !done) begin
      if (sbq.size() == 0) begin
        nCmp++; nBad++;
        $display("FAIL scoreboard empty rdData=%h expected none", rdData);
      end else begin
        item_t it;
        it = sbq.pop_front();
        nCmp++;
        if (rdData !== it.data || irqOut !== it.irq) begin
          nBad++;
          $display("FAIL %s rdData=%h irq=%b expected rdData=%h irq=%b",
                   it.req, rdData, irqOut, it.data, it.irq);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nCmp++; nBad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R2 reset state
    readReg("R2");
    // R4 HEC strobe, then R5 clear on read
    hecErrStb = 1'b1; tick("R4");
    readReg("R4");
    readReg("R5");
    // R3 symbol and overflow positions
    symErrStb = 1'b1; fifoOvfStb = 1'b1; tick("R4");
    readReg("R3");
    // R5 event in the same cycle as a read
    hecErrStb = 1'b1; rdEn = 1'b1; rdAddr = 8'h01; tick("R5");
    readReg("R5");
    // R1 other address returns zero and does not clear
    hecErrStb = 1'b1; tick("R4");
    rdEn = 1'b1; rdAddr = 8'h02; tick("R1");
    readReg("R1");
    readReg("R11");
    // R7 / R6 signal quality edges
    sigGood = 1'b1; tick("R7");
    readReg("R7");
    readReg("R6");
    sigGood = 1'b0; tick("R7");
    readReg("R7");
    // R8 parity
    txDataValid = 1'b1; txData = 8'h01; txParity = 1'b1; tick("R8");
    readReg("R8");
    parityChkEn = 1'b1;
    txDataValid = 1'b1; txData = 8'h01; txParity = 1'b1; tick("R8");
    readReg("R8");
    txDataValid = 1'b1; txData = 8'h01; txParity = 1'b0; tick("R8");
    readReg("R8");
    txDataValid = 1'b0; txData = 8'h03; txParity = 1'b1; tick("R8");
    readReg("R8");
    // R9 short cell, R10 saturation
    marker("R9");
    readReg("R9");
    sendBytes(CELL - 1);
    marker("R9");
    readReg("R9");
    sendBytes(CELL);
    marker("R10");
    readReg("R10");
    sendBytes(CELL + 17);
    marker("R10");
    readReg("R10");
    marker("R9");
    readReg("R9");
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule